// File: doc/BRIEF.md
# Backoff Spin-Lock Acquisition Engine

This block takes a lock word that lives in shared memory and acquires it for its host. When the host pulses an acquire request, the engine polls the word with ordinary reads. It stays in that loop for as long as the word reads as taken. It issues an atomic exchange only after a read shows the word as free. The exchange writes the taken value and returns the value the word held before. A returned zero means the host now owns the lock, and the engine raises a granted level. A nonzero return means another requester won the race. In that case the engine does not retry the exchange at once: it goes back to read polling.

Each failed check waits out a backoff interval before the next memory access. A failed check is either a read that shows the word as taken or an exchange that loses. The interval starts at one cycle and doubles after every failed check, up to a parameterised ceiling. A successful acquire sets it back to one cycle. This keeps short waits fast and makes long waits put little load on the memory.

A release pulse writes the free value back to the word and drops granted. A release that arrives while the lock is not held does nothing except raise a one-cycle error pulse. The memory side is a single request channel with a valid/ready handshake, followed by a response strobe. The shared memory, the arbitration between requesters and cache coherence are not part of this block.

Top module: `spin_lock_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, granted, busy, relError and memReqValid are all low.
- R2: After an acquire request the engine issues reads (memOp 0) to the lock address captured with the request. It issues no exchange while the latest read response is nonzero.
- R3: After a read returns 0, the next request is an exchange (memOp 1) with memWdata 1. If the exchange returns 0, granted goes high in the cycle after the response.
- R4: If an exchange returns nonzero, the next memory request is a read, not another exchange.
- R5: After a failed check, the next request is presented I+1 cycles after the cycle of the failing response. I is the current backoff interval. It starts at 1 and doubles after each failed check.
- R6: The backoff interval never exceeds MAX_BACKOFF. Doubling saturates at that value, even when MAX_BACKOFF is not a power of two.
- R7: A successful acquire resets the backoff interval to 1 for the next acquisition.
- R8: A release request while granted is high drops granted in the next cycle. It issues a write (memOp 2) of 0 to the lock address, and the engine returns to idle after the write response.
- R9: A release request while granted is low issues no memory request and changes no state. relError is high for exactly the following cycle.
- R10: An acquire request while the engine is not idle is ignored. While the lock is held, it issues no request and granted stays high.
- R11: While memReqValid is high and memReqReady is low, the request stays asserted with unchanged op, address and data. A stall delays the grant by the number of stalled cycles.
- R12: busy is high from the cycle after an acquire request until granted rises, and it is never high together with granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lockAddr | input | AW | Address of the lock word, captured on acquire |
| acqReq | input | 1 | One-cycle acquire request pulse |
| relReq | input | 1 | One-cycle release request pulse |
| granted | output | 1 | High while the lock is owned |
| busy | output | 1 | High while an acquire or release is in progress |
| relError | output | 1 | One-cycle pulse after a release while not holding |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memOp | output | 2 | 0 read, 1 exchange, 2 write |
| memAddr | output | AW | Request address |
| memWdata | output | DW | Write data (1 for exchange, 0 for write) |
| memRspValid | input | 1 | Response strobe, one per accepted request |
| memRspData | input | DW | Read or previous value returned |

## Verification
The bench loses exchange races on purpose. A design that retried the exchange straight away would issue one exchange too many and finish too early. Grant latency is measured across chains of busy polls long enough to hit a ceiling that is not a power of two. Wrong doubling, a missing clamp or a missing reset of the interval after a grant all show up as a wrong cycle count. The bench also stalls the ready line on the first poll, sends a release while idle and another during polling, and repeats an acquire while holding. A design that dropped or changed a stalled request, wrote memory on a bad release, or restarted from the held state would change the number of reads, the memory word or the granted level.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;

  typedef enum logic [1:0] {
    MEM_READ  = 2'd0,
    MEM_XCHG  = 2'd1,
    MEM_WRITE = 2'd2
  } memOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureAddr;
    logic loadWait;
    logic tickWait;
    logic growGap;
    logic clearGap;
  } lockStrobe_t;

endpackage

// File: rtl/spin_lock_dpath.sv
module spin_lock_dpath
  import spinlock_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int MAX_BACKOFF = 1024
) (
  input  logic          clk,
  input  logic          rstN,
  input  lockStrobe_t   strobe,
  input  memOp_e        curOp,
  input  logic [AW-1:0] lockAddr,
  input  logic [DW-1:0] memRspData,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          rspIsZero,
  output logic          waitDone
);

  localparam int CW = $clog2(MAX_BACKOFF + 1);
  localparam logic [CW:0] MAX_W = (CW + 1)'(MAX_BACKOFF);

  logic [AW-1:0] addrReg;
  logic [CW-1:0] gapReg;
  logic [CW-1:0] waitCnt;
  logic [CW:0]   gapDouble;
  logic [CW-1:0] gapNext;

  assign gapDouble = {gapReg, 1'b0};
  assign gapNext   = (gapDouble > MAX_W) ? MAX_W[CW-1:0] : gapDouble[CW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      gapReg  <= CW'(1);
      waitCnt <= CW'(1);
    end else begin
      if (strobe.captureAddr) addrReg <= lockAddr;
      if (strobe.clearGap)     gapReg <= CW'(1);
      else if (strobe.growGap) gapReg <= gapNext;
      if (strobe.loadWait)      waitCnt <= gapReg;
      else if (strobe.tickWait) waitCnt <= waitCnt - CW'(1);
    end
  end

  assign memAddr   = addrReg;
  assign memWdata  = (curOp == MEM_XCHG) ? DW'(1) : '0;
  assign rspIsZero = (memRspData == '0);
  assign waitDone  = (waitCnt == CW'(1));

endmodule

// File: rtl/spin_lock_ctrl.sv
module spin_lock_ctrl
  import spinlock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        acqReq,
  input  logic        relReq,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        rspIsZero,
  input  logic        waitDone,
  output logic        memReqValid,
  output memOp_e      curOp,
  output lockStrobe_t strobe,
  output logic        granted,
  output logic        busy,
  output logic        relError
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_POLL_REQ, ST_POLL_WAIT, ST_XCHG_REQ, ST_XCHG_WAIT,
    ST_BACKOFF, ST_HELD, ST_REL_REQ, ST_REL_WAIT
  } lockState_e;

  lockState_e state, stateNext;
  logic       relErrReg;

  always_comb begin
    stateNext   = state;
    memReqValid = 1'b0;
    curOp       = MEM_READ;
    strobe      = '0;
    unique case (state)
      ST_IDLE: if (acqReq) begin
        strobe.captureAddr = 1'b1;
        stateNext = ST_POLL_REQ;
      end
      ST_POLL_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_POLL_WAIT;
      end
      ST_POLL_WAIT: if (memRspValid) begin
        if (rspIsZero) stateNext = ST_XCHG_REQ;
        else begin
          strobe.loadWait = 1'b1;
          strobe.growGap  = 1'b1;
          stateNext = ST_BACKOFF;
        end
      end
      ST_XCHG_REQ: begin
        memReqValid = 1'b1;
        curOp = MEM_XCHG;
        if (memReqReady) stateNext = ST_XCHG_WAIT;
      end
      ST_XCHG_WAIT: if (memRspValid) begin
        if (rspIsZero) begin
          strobe.clearGap = 1'b1;
          stateNext = ST_HELD;
        end else begin
          strobe.loadWait = 1'b1;
          strobe.growGap  = 1'b1;
          stateNext = ST_BACKOFF;
        end
      end
      ST_BACKOFF: begin
        strobe.tickWait = 1'b1;
        if (waitDone) stateNext = ST_POLL_REQ;
      end
      ST_HELD: if (relReq) stateNext = ST_REL_REQ;
      ST_REL_REQ: begin
        memReqValid = 1'b1;
        curOp = MEM_WRITE;
        if (memReqReady) stateNext = ST_REL_WAIT;
      end
      ST_REL_WAIT: if (memRspValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      relErrReg <= 1'b0;
    end else begin
      state     <= stateNext;
      relErrReg <= relReq && (state != ST_HELD);
    end
  end

  assign granted  = (state == ST_HELD);
  assign busy     = (state != ST_IDLE) && (state != ST_HELD);
  assign relError = relErrReg;

endmodule

// File: rtl/spin_lock_engine.sv
module spin_lock_engine
  import spinlock_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int MAX_BACKOFF = 1024
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] lockAddr,
  input  logic          acqReq,
  input  logic          relReq,
  output logic          granted,
  output logic          busy,
  output logic          relError,
  output logic          memReqValid,
  input  logic          memReqReady,
  output logic [1:0]    memOp,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memRspValid,
  input  logic [DW-1:0] memRspData
);

  lockStrobe_t strobe;
  memOp_e      curOp;
  logic        rspIsZero;
  logic        waitDone;

  spin_lock_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .acqReq(acqReq), .relReq(relReq),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .rspIsZero(rspIsZero), .waitDone(waitDone),
    .memReqValid(memReqValid), .curOp(curOp), .strobe(strobe),
    .granted(granted), .busy(busy), .relError(relError)
  );

  spin_lock_dpath #(.AW(AW), .DW(DW), .MAX_BACKOFF(MAX_BACKOFF)) dpathI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curOp(curOp),
    .lockAddr(lockAddr), .memRspData(memRspData),
    .memAddr(memAddr), .memWdata(memWdata),
    .rspIsZero(rspIsZero), .waitDone(waitDone)
  );

  assign memOp = curOp;

endmodule

// File: rtl/spin_lock_engine_chk.sv
module spin_lock_engine_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int MAX_BACKOFF = 1024
) (
  input logic          clk,
  input logic          rstN,
  input logic          relReq,
  input logic          granted,
  input logic          busy,
  input logic          relError,
  input logic          memReqValid,
  input logic          memReqReady,
  input logic [1:0]    memOp,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memWdata,
  input logic          memRspValid,
  input logic [DW-1:0] memRspData
);

  logic [1:0] pendOp;
  logic       lastReadZero;
  int         quietRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendOp       <= 2'd0;
      lastReadZero <= 1'b0;
      quietRun     <= 0;
    end else begin
      if (memReqValid && memReqReady) pendOp <= memOp;
      if (memRspValid && pendOp == 2'd0) lastReadZero <= (memRspData == '0);
      if (busy && !memReqValid) quietRun <= quietRun + 1;
      else quietRun <= 0;
    end
  end

  assert_stall_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memOp) && $stable(memAddr) && $stable(memWdata));

  assert_xchg_after_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memOp == 2'd1 |-> lastReadZero);

  assert_xchg_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memOp == 2'd1 |-> memWdata == DW'(1));

  assert_grant_on_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(granted) |-> $past(memRspValid) && $past(memRspData) == '0);

  assert_release_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memOp == 2'd2 |-> memWdata == '0);

  assert_bad_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(relReq) && !$past(granted) |-> relError);

  assert_backoff_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    quietRun <= MAX_BACKOFF + 1);

  assert_busy_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && granted));

endmodule

bind spin_lock_engine spin_lock_engine_chk #(.AW(AW), .DW(DW), .MAX_BACKOFF(MAX_BACKOFF)) chkI (
  .clk(clk), .rstN(rstN), .relReq(relReq), .granted(granted), .busy(busy),
  .relError(relError), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memOp(memOp), .memAddr(memAddr), .memWdata(memWdata),
  .memRspValid(memRspValid), .memRspData(memRspData)
);

// File: tb/spin_lock_engine_test.sv
`timescale 1ns/1ps
module spin_lock_engine_test;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int MAXB = 20;
  localparam logic [AW-1:0] LOCK_ADDR = 8'h05;

  typedef struct packed { int hold; int steal; int stall; } vec_t;
  localparam vec_t VECS [7] = '{
    '{0, 0, 0}, '{1, 0, 0}, '{3, 0, 0}, '{0, 1, 0},
    '{6, 1, 0}, '{2, 0, 0}, '{0, 0, 3}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] lockAddr = LOCK_ADDR;
  logic          acqReq = 1'b0;
  logic          relReq = 1'b0;
  logic          granted, busy, relError, memReqValid;
  logic          memReqReady = 1'b1;
  logic [1:0]    memOp;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memRspValid = 1'b0;
  logic [DW-1:0] memRspData = '0;

  spin_lock_engine #(.AW(AW), .DW(DW), .MAX_BACKOFF(MAXB)) uut (
    .clk(clk), .rstN(rstN), .lockAddr(lockAddr), .acqReq(acqReq), .relReq(relReq),
    .granted(granted), .busy(busy), .relError(relError),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memOp(memOp),
    .memAddr(memAddr), .memWdata(memWdata),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  // memory model state
  logic [DW-1:0] lockWord = '0;
  int  heldReads = 0;
  bit  stealNext = 0;
  int  stallLeft = 0;
  bit  pending = 0;
  logic [1:0]    pOp;
  logic [DW-1:0] pData;
  int  reqCount = 0, readCount = 0, xchgCount = 0, writeCount = 0, badAddr = 0;
  logic [DW-1:0] lastReadVal = '0;
  int  badXchg = 0, badAfterLoss = 0;
  bit  lostXchg = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (pending) begin
      logic [DW-1:0] rv;
      pending = 0;
      case (pOp)
        2'd0: begin
          if (heldReads > 0) begin rv = 1; heldReads--; end
          else rv = lockWord;
          lastReadVal = rv;
        end
        2'd1: begin
          if (stealNext) begin rv = 1; stealNext = 0; heldReads = 1; lostXchg = 1; end
          else if (heldReads > 0) begin rv = 1; lostXchg = 1; end
          else begin rv = lockWord; lockWord = 1; end
        end
        default: begin rv = 0; lockWord = pData; end
      endcase
      memRspValid = 1'b1;
      memRspData  = rv;
    end else begin
      memRspValid = 1'b0;
      memRspData  = '0;
    end
    memReqReady = (stallLeft == 0);
    if (memReqValid && stallLeft > 0) stallLeft--;
    if (memReqValid && memReqReady) begin
      pending = 1;
      pOp = memOp;
      pData = memWdata;
      reqCount++;
      if (memAddr != LOCK_ADDR) badAddr++;
      if (memOp == 2'd0) readCount++;
      if (memOp == 2'd1) begin
        xchgCount++;
        if (lastReadVal != 0) badXchg++;
      end
      if (memOp == 2'd2) writeCount++;
      if (lostXchg && memOp != 2'd0) badAfterLoss++;
      if (memOp != 2'd2) lostXchg = 0;
    end
  end

  function automatic int growGap(input int g);
    return (2 * g > MAXB) ? MAXB : 2 * g;
  endfunction

  function automatic int expLatency(input vec_t v);
    int g = 1;
    int s = 0;
    for (int k = 0; k < v.hold; k++) begin s += 2 + g; g = growGap(g); end
    s += 2;
    if (v.steal != 0) begin
      s += 2 + g; g = growGap(g);
      s += 2 + g; g = growGap(g);
      s += 2;
    end
    s += 2;
    return 1 + s + v.stall;
  endfunction

  task automatic acquire(output int n, output int busyBad);
    busyBad = 0;
    acqReq = 1'b1;
    @(negedge clk);
    acqReq = 1'b0;
    n = 1;
    while (!granted && n < 20000) begin
      if (!busy) busyBad++;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic release_lock(input string tag);
    relReq = 1'b1;
    @(negedge clk);
    relReq = 1'b0;
    chk(granted == 1'b0, {tag, " R8 granted after release"}, granted, 0);
    while (busy) @(negedge clk);
    chk(lockWord == 0, {tag, " R8 lock word freed"}, lockWord, 0);
  endtask

  initial begin
    int n, bb, r0, x0, w0, q0;
    lockWord = 0;
    repeat (3) @(negedge clk);
    chk(!granted && !busy && !relError && !memReqValid, "R1 in reset",
        {granted, busy, relError, memReqValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!granted && !busy && !relError && !memReqValid, "R1 after reset",
        {granted, busy, relError, memReqValid}, 0);

    // vector table: busy polls, lost exchange, stalled ready
    for (int i = 0; i < 7; i++) begin
      vec_t v = VECS[i];
      heldReads = v.hold;
      stealNext = (v.steal != 0);
      stallLeft = v.stall;
      r0 = readCount; x0 = xchgCount; w0 = writeCount;
      acquire(n, bb);
      chk(n == expLatency(v), $sformatf("R5 R6 R7 R11 grant latency vec%0d", i), n, expLatency(v));
      chk(granted && !busy, $sformatf("R3 R12 granted vec%0d", i), {granted, busy}, 2);
      chk(bb == 0, $sformatf("R12 busy while acquiring vec%0d", i), bb, 0);
      chk(readCount - r0 == v.hold + 1 + 2 * v.steal, $sformatf("R2 read count vec%0d", i),
          readCount - r0, v.hold + 1 + 2 * v.steal);
      chk(xchgCount - x0 == 1 + v.steal, $sformatf("R4 exchange count vec%0d", i),
          xchgCount - x0, 1 + v.steal);
      chk(lockWord == 1, $sformatf("R3 lock word set vec%0d", i), lockWord, 1);
      release_lock($sformatf("vec%0d", i));
      chk(writeCount - w0 == 1, $sformatf("R8 one write vec%0d", i), writeCount - w0, 1);
    end
    chk(badXchg == 0, "R2 no exchange after nonzero read", badXchg, 0);
    chk(badAfterLoss == 0, "R4 read follows lost exchange", badAfterLoss, 0);
    chk(badAddr == 0, "R2 R8 request address", badAddr, 0);

    // release while idle
    q0 = reqCount;
    lockWord = 1;
    relReq = 1'b1;
    @(negedge clk);
    relReq = 1'b0;
    chk(relError == 1'b1, "R9 error pulse", relError, 1);
    @(negedge clk);
    chk(relError == 1'b0, "R9 error pulse one cycle", relError, 0);
    repeat (3) @(negedge clk);
    chk(reqCount == q0 && lockWord == 1, "R9 no memory access", reqCount - q0, 0);
    chk(!busy && !granted, "R9 still idle", {busy, granted}, 0);
    lockWord = 0;

    // release during polling, then acquire again while held
    heldReads = 4;
    acqReq = 1'b1;
    @(negedge clk);
    acqReq = 1'b0;
    repeat (2) @(negedge clk);
    relReq = 1'b1;
    @(negedge clk);
    relReq = 1'b0;
    chk(relError == 1'b1, "R9 error during polling", relError, 1);
    n = 0;
    while (!granted && n < 20000) begin @(negedge clk); n++; end
    chk(granted == 1'b1, "R9 acquire continues after bad release", granted, 1);
    q0 = reqCount;
    acqReq = 1'b1;
    @(negedge clk);
    acqReq = 1'b0;
    repeat (5) @(negedge clk);
    chk(reqCount == q0, "R10 no request on acquire while held", reqCount - q0, 0);
    chk(granted && !busy, "R10 still held", {granted, busy}, 2);
    release_lock("final");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule